// File: doc/BRIEF.md
# Masked-Write GPIO Port Controller

This block drives a 32-pin general-purpose I/O port from a simple memory-mapped register port made of a valid strobe, a write flag, a byte address and a 32-bit data word. Each pin has a direction bit and an output-value bit. Both drive the pad-side output-enable and output-value vectors directly. The pad input levels pass through a synchronizer and can be read back as one 32-bit word.

Direction is changed only through a write-one-to-set word and a write-one-to-clear word, so one pin can be switched without disturbing the others. Output values are written one half-word at a time. Each write carries its own 16-bit bit-enable mask in the upper half, so software can change single pins without first reading the register. The output-value bits keep their contents while a pin is an input. This lets software preload a level before it turns the pin around.

Top module: `gpio_mask_port`

## Requirements
- R1: A write to offset 0x00 turns into an output every pin whose data bit is 1. Pins whose data bit is 0 keep their direction. padOe shows the new direction after the clock edge that accepts the write.
- R2: A write to offset 0x04 turns into an input every pin whose data bit is 1. Pins whose data bit is 0 keep their direction.
- R3: A write to offset 0x08 affects only the output values of pins 0 to 15. A write to offset 0x0C affects only the output values of pins 16 to 31, with data bit k mapping to pin 16+k.
- R4: In an output-value write, data bits 31:16 are a per-pin enable and bits 15:0 are the new levels. Only pins whose enable bit is 1 take the new level. All other pins keep their value.
- R5: A read of offset 0x10 returns the pad input levels after a two-flop synchronizer. A level applied before clock edge k is returned by a read accepted at edge k+2. A read accepted at edge k+1 still returns the previous level.
- R6: The output value of a pin is held and drives padOut whatever the pin's direction. Direction writes never change output values.
- R7: After reset, all pins are inputs (padOe = 0), all output values are 0 (padOut = 0) and the read data is 0.
- R8: Reads of 0x00 and 0x04 return the 32-bit direction vector (1 = output). Reads of 0x08 and 0x0C return the full 32-bit output-value vector.
- R9: Reads of any other offset, including unaligned ones, return 0. Writes to them, and writes to 0x10, change no state.
- R10: Read data is registered. It updates on the edge that accepts a read and holds its value while no read is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Register access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| padIn | input | 32 | Asynchronous pad input levels |
| padOe | output | 32 | Per-pin output enable (direction) |
| padOut | output | 32 | Per-pin output level |

## Verification
A wrong direction or output-value bit shows up on padOe or padOut on the cycle right after the write that caused it. The bench compares both vectors against an arithmetic model after every write of a long pseudo-random sequence over mapped and unmapped offsets. A wrong read decode or a stale read register appears on busRdata one edge after the read is accepted. A synchronizer with the wrong depth shows up as data arriving one edge early or late when the bench probes the input path at both edge k+1 and edge k+2.

// File: rtl/gmp_pkg.sv
package gmp_pkg;
  localparam int PIN_COUNT  = 32;
  localparam int DATA_W     = 32;
  localparam int HALF_W     = DATA_W / 2;
  localparam int NUM_HALVES = PIN_COUNT / HALF_W;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_DIR  = 2'd1,
    RD_OUT  = 2'd2,
    RD_PAD  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic                  dirSet;
    logic                  dirClr;
    logic [NUM_HALVES-1:0] outWr;
    logic                  rdEn;
    rdSel_e                rdSel;
  } strobe_t;
endpackage

// File: rtl/gmp_ctrl.sv
module gmp_ctrl
  import gmp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  localparam logic [ADDR_W-1:0] OFS_DIR_SET = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_DIR_CLR = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_OUT_LO  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_PAD_IN  = ADDR_W'(8'h10);
  localparam int              HALF_STEP   = 4;

  logic hitDirSet, hitDirClr, hitPad;
  logic [NUM_HALVES-1:0] hitOut;

  assign hitDirSet = (busAddr == OFS_DIR_SET);
  assign hitDirClr = (busAddr == OFS_DIR_CLR);
  assign hitPad    = (busAddr == OFS_PAD_IN);

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_outHit
    assign hitOut[h] = (busAddr == OFS_OUT_LO + ADDR_W'(h * HALF_STEP));
  end

  logic wrReq, rdReq;
  assign wrReq = busValid && busWrite;
  assign rdReq = busValid && !busWrite;

  always_comb begin
    strb        = '0;
    strb.dirSet = wrReq && hitDirSet;
    strb.dirClr = wrReq && hitDirClr;
    strb.outWr  = wrReq ? hitOut : '0;
    strb.rdEn   = rdReq;
    if (hitDirSet || hitDirClr) strb.rdSel = RD_DIR;
    else if (|hitOut)           strb.rdSel = RD_OUT;
    else if (hitPad)            strb.rdSel = RD_PAD;
    else                        strb.rdSel = RD_ZERO;
  end

  // R9: reads never raise a state-changing strobe
  p_read_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busValid && !busWrite) |-> !(strb.dirSet || strb.dirClr || (|strb.outWr)));
  // R3: at most one state-changing strobe per access
  p_single_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.dirSet, strb.dirClr, strb.outWr}));
endmodule

// File: rtl/gmp_datapath.sv
module gmp_datapath
  import gmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobe_t              strb,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut
);
  logic [PIN_COUNT-1:0] dirReg;
  logic [HALF_W-1:0]    outHalf [NUM_HALVES];
  logic [PIN_COUNT-1:0] syncQ   [SYNC_STAGES];
  logic [HALF_W-1:0]    wrMask, wrVal;

  assign wrMask = wdata[DATA_W-1:HALF_W];
  assign wrVal  = wdata[HALF_W-1:0];

  // direction: set and clear strobes never coincide
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           dirReg <= '0;
    else if (strb.dirSet) dirReg <= dirReg | wdata;
    else if (strb.dirClr) dirReg <= dirReg & ~wdata;
  end

  // output values: one masked register per half-word
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_outHalf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             outHalf[h] <= '0;
      else if (strb.outWr[h]) outHalf[h] <= (outHalf[h] & ~wrMask) | (wrVal & wrMask);
    end
    assign padOut[h*HALF_W +: HALF_W] = outHalf[h];
  end

  // input synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign padOe = dirReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (strb.rdEn) begin
      unique case (strb.rdSel)
        RD_DIR:  rdata <= dirReg;
        RD_OUT:  rdata <= padOut;
        RD_PAD:  rdata <= syncQ[SYNC_STAGES-1];
        default: rdata <= '0;
      endcase
    end
  end

  p_dir_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.dirSet |=> ((padOe & $past(wdata)) == $past(wdata)));
  p_dir_set_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.dirSet |=> ((padOe & ~$past(wdata)) == ($past(padOe) & ~$past(wdata))));
  p_dir_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.dirClr |=> ((padOe & $past(wdata)) == '0));
  p_lo_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.outWr[0] |=> (((padOut ^ $past(padOut)) &
                        ~{{HALF_W{1'b0}}, $past(wdata[DATA_W-1:HALF_W])}) == '0));
  p_hi_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.outWr[1] |=> (((padOut ^ $past(padOut)) &
                        ~{$past(wdata[DATA_W-1:HALF_W]), {HALF_W{1'b0}}}) == '0));
  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|strb.outWr) |=> $stable(padOut));
  p_dir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.dirSet || strb.dirClr) |=> $stable(padOe));
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.rdEn |=> $stable(rdata));
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gmp_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut
);
  strobe_t strb;

  gmp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .strb(strb)
  );

  gmp_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wdata(busWdata), .rdata(busRdata),
    .padIn(padIn), .padOe(padOe), .padOut(padOut)
  );
endmodule

// File: tb/sim_gpio_mask_port.sv
`timescale 1ns/1ps
module sim_gpio_mask_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [31:0] padIn = '0, padOe, padOut;

  int checks = 0, failures = 0;
  logic [31:0] dirM = '0, outM = '0, rnd = 32'h1234_5678;

  always #2 clk = ~clk;

  gpio_mask_port u0 (
    .clk(clk), .rst_n(rst_n), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOe(padOe), .padOut(padOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRnd(input logic [31:0] x);
    logic [31:0] y = x;
    y ^= y << 13; y ^= y >> 17; y ^= y << 5;
    return y;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
    case (a)
      8'h00: dirM = dirM | d;
      8'h04: dirM = dirM & ~d;
      8'h08: outM[15:0]  = (outM[15:0]  & ~d[31:16]) | (d[15:0] & d[31:16]);
      8'h0C: outM[31:16] = (outM[31:16] & ~d[31:16]) | (d[15:0] & d[31:16]);
      default: ;
    endcase
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    @(negedge clk);
    busValid = 1'b0;
    d = busRdata;
  endtask

  function automatic logic [31:0] expRead(input logic [7:0] a);
    case (a)
      8'h00, 8'h04: return dirM;
      8'h08, 8'h0C: return outM;
      8'h10:        return padIn;
      default:      return 32'h0;
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] r, held;
    logic [7:0]  addrs [9];
    addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h01, 8'h20, 8'hFC};

    repeat (3) @(negedge clk);
    check("R7 oe", padOe, 32'h0);
    check("R7 out", padOut, 32'h0);
    check("R7 rdata", busRdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2: walk every pin through set then clear
    for (int i = 0; i < 32; i++) begin
      wr(8'h00, 32'h1 << i);
      check("R1 set walk", padOe, dirM);
      rd(8'h04, r);
      check("R8 dir read", r, dirM);
    end
    for (int i = 0; i < 32; i += 2) begin
      wr(8'h04, 32'h1 << i);
      check("R2 clr walk", padOe, dirM);
    end
    check("R2 pattern", padOe, 32'hAAAA_AAAA);
    check("R6 dir no out change", padOut, 32'h0);

    // R3 / R4: each output pin through its own masked half
    for (int i = 0; i < 16; i++) begin
      wr(8'h08, (32'h1 << (i + 16)) | 32'hFFFF);
      check("R4 lo single pin", padOut, outM);
      wr(8'h0C, (32'h1 << (i + 16)) | 32'hFFFF);
      check("R3 hi single pin", padOut, outM);
    end
    check("R3 all ones", padOut, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0000_0000);
    check("R4 zero mask no change", padOut, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hF0F0_0000);
    check("R4 hi masked clear", padOut, 32'h0F0F_FFFF);

    // R6: value preloaded while input, kept across direction change
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'h00FF_0055);
    check("R6 preload while input", padOut, outM);
    wr(8'h00, 32'h0000_00FF);
    check("R6 value kept after turnaround", padOut, outM);
    check("R1 turnaround oe", padOe, 32'h0000_00FF);

    // R9: writes to read-only and unmapped offsets
    held = padOut;
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF); wr(8'hFC, 32'hFFFF_FFFF);
    check("R9 unmapped write out", padOut, held);
    check("R9 unmapped write oe", padOe, 32'h0000_00FF);

    // R5: synchronizer latency
    padIn = 32'hA5A5_0001;
    @(negedge clk);
    rd(8'h10, r);
    check("R5 one edge early old", r, 32'h0);
    padIn = 32'h3C3C_8000;
    repeat (2) @(negedge clk);
    rd(8'h10, r);
    check("R5 two edges visible", r, 32'h3C3C_8000);
    for (int i = 0; i < 32; i++) begin
      padIn = 32'h1 << i;
      repeat (2) @(negedge clk);
      rd(8'h10, r);
      check("R5 walk", r, padIn);
    end

    // R10: read data holds without a read
    rd(8'h08, r);
    wr(8'h08, 32'hFFFF_0000);
    repeat (2) @(negedge clk);
    check("R10 hold", busRdata, r);

    // random sweep over mapped and unmapped offsets
    padIn = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk);
    for (int n = 0; n < 600; n++) begin
      logic [7:0] a;
      rnd = nextRnd(rnd);
      a = addrs[rnd[3:0] % 9];
      rnd = nextRnd(rnd);
      if (rnd[0]) begin
        wr(a, nextRnd(rnd));
        check("R1 R2 R3 R4 sweep oe", padOe, dirM);
        check("R3 R4 R6 sweep out", padOut, outM);
      end else begin
        rd(a, r);
        check("R8 R9 sweep read", r, expRead(a));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule